// File: doc/BRIEF.md
# Time-of-Day Counter with Command Unit

This block keeps a running time of day made of a 48-bit seconds count, a 32-bit nanoseconds count and a 32-bit fraction of a nanosecond in units of 2^-32 ns. The time moves forward on every clock by a programmable step. That step is a whole-nanosecond value plus a signed fractional offset. A signed rate trim is added to the step on top of that.

Software drives the block through a 16-bit register port. It fills a set of operand registers and then writes a function code together with a trigger bit. The available functions are:
- load the time;
- set the rate trim;
- add the operand to the time;
- subtract the operand from the time;
- snapshot the time.

A rising edge on the external event input runs the stored function code. That input cannot be masked. A snapshot lands in one of two capture slots, and each slot has its own valid flag.

Register addresses (5-bit word addresses; only bits 15:0 are carried):
- 0 is the run control. Bit 0 is an active-low core reset.
- 1 is the function register. Bit 0 is the trigger and bits 4:2 hold the code.
- 2 to 4 hold the operand seconds, high word first.
- 5 and 6 hold the operand nanoseconds, high word first.
- 7 and 8 hold the operand fraction, high word first.
- 9 holds the whole-nanosecond step.
- 10 and 11 hold the fractional step, high word first.
- 12 is the status register.
- 16 to 22 read slot 0 and 24 to 30 read slot 1. Each slot returns seven words: seconds high, middle and low, then nanoseconds high and low, then fraction high and low.

Top module: `tod_cmd_unit`

## Requirements
- R1: After reset the status register (address 12) reads 0. While run-control bit 0 is 0, the time is held at zero and every trigger, from software or from the event input, is ignored. The cycle in which bit 0 is set still sees a zero time.
- R2: While running, each clock adds stepNs·2^32 + stepFrac + trim to the time. In that sum stepFrac and trim are signed 32-bit values in 2^-32 ns units. The step resets to 3 ns with a zero fraction.
- R3: When nanoseconds reach 10^9 they wrap, and one carry goes into seconds.
- R4: Code 0 loads seconds, nanoseconds and fraction from the operand registers. The loaded value is present in the cycle after the trigger.
- R5: Code 1 copies the operand fraction into the signed rate trim. The trim takes effect from the next step onward.
- R6: Code 2 adds the operand seconds and nanoseconds to the time after that cycle's step. A nanosecond overflow carries into seconds.
- R7: Code 3 subtracts the operand seconds and nanoseconds from the time after that cycle's step. If the nanoseconds would go negative, 10^9 is added to them and one is borrowed from seconds.
- R8: Code 4 copies the time present in the trigger cycle into slot 0 if that slot is free, otherwise into slot 1. When both slots are full the capture is dropped and neither slot changes.
- R9: Status bit 0 shows that slot 0 is valid and bit 1 shows that slot 1 is valid. A read strobe on a slot's last word (address 22 or 30) clears that slot's flag.
- R10: A write to the function register with bit 0 set runs the code carried in bits 4:2 of that same write. A write with bit 0 clear only stores the code. Codes 5 to 7 perform no action.
- R11: A rising edge on the event input runs the stored code once, regardless of how long the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | counter clock |
| rst | input | 1 | synchronous reset, active high |
| wrEn | input | 1 | register write strobe |
| wrAddr | input | 5 | register write address |
| wrData | input | 16 | register write data |
| rdEn | input | 1 | read strobe (clears a slot flag on the slot's last word) |
| rdAddr | input | 5 | register read address |
| rdData | output | 16 | combinational read data for rdAddr |
| evtIn | input | 1 | external event input, synchronous, rising-edge active |

## Verification
Register writes take effect at the edge that samples them. A triggered function therefore shows its result in the time value one cycle later. A capture records the value present before the trigger edge. The time captured after a trigger is the operand plus one step for every clock edge between the trigger and the capture trigger. The bench counts those edges exactly, because each of its write, read and idle tasks spends exactly one edge. Read data is combinational and is sampled one time unit after a falling edge. Flag clears show up on the status read that follows.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int SEC_W  = 48;
  localparam int NS_W   = 32;
  localparam int FRAC_W = 32;
  localparam int ADDR_W = 5;
  localparam int WORD_W = 16;
  localparam int NSLOT  = 2;

  localparam logic [ADDR_W-1:0] A_RUN    = 5'd0;
  localparam logic [ADDR_W-1:0] A_FUNC   = 5'd1;
  localparam logic [ADDR_W-1:0] A_LSECH  = 5'd2;
  localparam logic [ADDR_W-1:0] A_LSECM  = 5'd3;
  localparam logic [ADDR_W-1:0] A_LSECL  = 5'd4;
  localparam logic [ADDR_W-1:0] A_LNSH   = 5'd5;
  localparam logic [ADDR_W-1:0] A_LNSL   = 5'd6;
  localparam logic [ADDR_W-1:0] A_LFRH   = 5'd7;
  localparam logic [ADDR_W-1:0] A_LFRL   = 5'd8;
  localparam logic [ADDR_W-1:0] A_STEPNS = 5'd9;
  localparam logic [ADDR_W-1:0] A_STEPFH = 5'd10;
  localparam logic [ADDR_W-1:0] A_STEPFL = 5'd11;
  localparam logic [ADDR_W-1:0] A_STATUS = 5'd12;
  localparam logic [2:0] LAST_WORD = 3'd6;

  typedef enum logic [2:0] {
    FN_LOAD = 3'd0, FN_FREQ = 3'd1, FN_INC = 3'd2,
    FN_DEC = 3'd3, FN_CAPTURE = 3'd4, FN_NOP = 3'd7
  } todFn_e;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [NS_W-1:0]   ns;
    logic [FRAC_W-1:0] frac;
  } todTime_t;

  typedef struct packed {
    logic load;
    logic freq;
    logic inc;
    logic dec;
    logic capture;
    logic [NSLOT-1:0] clear;
  } todCmd_t;
endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int STEP_NS_INIT   = 3,
  parameter int STEP_FRAC_INIT = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [WORD_W-1:0]    wrData,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [WORD_W-1:0]    rdData,
  input  logic                 evtIn,
  input  todTime_t [NSLOT-1:0] slotTime,
  input  logic [NSLOT-1:0]     slotValid,
  output logic                 run,
  output todTime_t             loadVal,
  output logic [15:0]          stepNs,
  output logic [FRAC_W-1:0]    stepFrac,
  output todCmd_t              cmd
);
  logic [2:0] fnCode;
  logic       evtPrev;
  logic       swTrig;
  logic       evtRise;
  logic       trig;
  logic [2:0] useCode;

  assign swTrig  = wrEn && (wrAddr == A_FUNC) && wrData[0];
  assign evtRise = evtIn && !evtPrev;
  assign trig    = run && (swTrig || evtRise);
  assign useCode = swTrig ? wrData[4:2] : fnCode;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      fnCode   <= FN_NOP;
      evtPrev  <= 1'b0;
      loadVal  <= '0;
      stepNs   <= 16'(STEP_NS_INIT);
      stepFrac <= 32'(STEP_FRAC_INIT);
    end else begin
      evtPrev <= evtIn;
      if (wrEn) begin
        case (wrAddr)
          A_RUN:    run                  <= wrData[0];
          A_FUNC:   fnCode               <= wrData[4:2];
          A_LSECH:  loadVal.sec[47:32]   <= wrData;
          A_LSECM:  loadVal.sec[31:16]   <= wrData;
          A_LSECL:  loadVal.sec[15:0]    <= wrData;
          A_LNSH:   loadVal.ns[31:16]    <= wrData;
          A_LNSL:   loadVal.ns[15:0]     <= wrData;
          A_LFRH:   loadVal.frac[31:16]  <= wrData;
          A_LFRL:   loadVal.frac[15:0]   <= wrData;
          A_STEPNS: stepNs               <= wrData;
          A_STEPFH: stepFrac[31:16]      <= wrData;
          A_STEPFL: stepFrac[15:0]       <= wrData;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cmd.load    = trig && (useCode == FN_LOAD);
    cmd.freq    = trig && (useCode == FN_FREQ);
    cmd.inc     = trig && (useCode == FN_INC);
    cmd.dec     = trig && (useCode == FN_DEC);
    cmd.capture = trig && (useCode == FN_CAPTURE);
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_clear
    assign cmd.clear[i] = rdEn && rdAddr[4] && (rdAddr[3] == 1'(i)) && (rdAddr[2:0] == LAST_WORD);
  end

  function automatic logic [WORD_W-1:0] slotWord(input todTime_t t, input logic [2:0] w);
    case (w)
      3'd0: return t.sec[47:32];
      3'd1: return t.sec[31:16];
      3'd2: return t.sec[15:0];
      3'd3: return t.ns[31:16];
      3'd4: return t.ns[15:0];
      3'd5: return t.frac[31:16];
      3'd6: return t.frac[15:0];
      default: return '0;
    endcase
  endfunction

  always_comb begin
    rdData = '0;
    if (rdAddr[4]) rdData = slotWord(slotTime[rdAddr[3]], rdAddr[2:0]);
    else begin
      case (rdAddr)
        A_RUN:    rdData = {15'd0, run};
        A_FUNC:   rdData = {11'd0, fnCode, 2'b00};
        A_STATUS: rdData = {{(WORD_W-NSLOT){1'b0}}, slotValid};
        default:  rdData = '0;
      endcase
    end
  end

  p_held_nocmd_r1: assert property (@(posedge clk) disable iff (rst)
    !run |-> !(cmd.load || cmd.freq || cmd.inc || cmd.dec || cmd.capture));

  p_sw_code_r10: assert property (@(posedge clk) disable iff (rst)
    (run && wrEn && wrAddr == A_FUNC && wrData[0] && wrData[4:2] == FN_INC) |-> cmd.inc);

  p_evt_capture_r11: assert property (@(posedge clk) disable iff (rst)
    (run && $rose(evtIn) && fnCode == FN_CAPTURE && !(wrEn && wrAddr == A_FUNC)) |-> cmd.capture);

  p_evt_once_r11: assert property (@(posedge clk) disable iff (rst)
    (evtIn && $past(evtIn) && !wrEn) |-> !cmd.capture);
endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  todTime_t             loadVal,
  input  logic [15:0]          stepNs,
  input  logic [FRAC_W-1:0]    stepFrac,
  input  todCmd_t              cmd,
  output todTime_t [NSLOT-1:0] slotTime,
  output logic [NSLOT-1:0]     slotValid
);
  localparam int ACC_W = 50;
  localparam logic [NS_W:0] NS_LIM = (NS_W+1)'(NS_PER_SEC);

  todTime_t          tod;
  todTime_t          stepped;
  todTime_t          nxt;
  logic [FRAC_W-1:0] trim;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W-33:0] carry;
  logic [NS_W:0]     nsSum;
  logic [NS_W:0]     nsAdj;

  always_comb begin
    acc = ACC_W'(tod.frac) + ACC_W'({stepNs, 32'd0})
        + {{(ACC_W-FRAC_W){stepFrac[FRAC_W-1]}}, stepFrac}
        + {{(ACC_W-FRAC_W){trim[FRAC_W-1]}}, trim};
    carry = acc[ACC_W-1:32];
    nsSum = {1'b0, tod.ns} + (NS_W+1)'(carry);
    stepped.frac = acc[31:0];
    if (nsSum >= NS_LIM) begin
      stepped.ns  = NS_W'(nsSum - NS_LIM);
      stepped.sec = tod.sec + 48'd1;
    end else begin
      stepped.ns  = nsSum[NS_W-1:0];
      stepped.sec = tod.sec;
    end

    nxt   = stepped;
    nsAdj = '0;
    if (cmd.load) begin
      nxt = loadVal;
    end else if (cmd.inc) begin
      nsAdj = {1'b0, stepped.ns} + {1'b0, loadVal.ns};
      if (nsAdj >= NS_LIM) begin
        nxt.ns  = NS_W'(nsAdj - NS_LIM);
        nxt.sec = stepped.sec + loadVal.sec + 48'd1;
      end else begin
        nxt.ns  = nsAdj[NS_W-1:0];
        nxt.sec = stepped.sec + loadVal.sec;
      end
    end else if (cmd.dec) begin
      if (stepped.ns >= loadVal.ns) begin
        nxt.ns  = stepped.ns - loadVal.ns;
        nxt.sec = stepped.sec - loadVal.sec;
      end else begin
        nsAdj   = NS_LIM + {1'b0, stepped.ns} - {1'b0, loadVal.ns};
        nxt.ns  = nsAdj[NS_W-1:0];
        nxt.sec = stepped.sec - loadVal.sec - 48'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tod  <= '0;
      trim <= '0;
    end else begin
      tod <= run ? nxt : '0;
      if (cmd.freq) trim <= loadVal.frac;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slotTime  <= '0;
      slotValid <= '0;
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (cmd.clear[i]) slotValid[i] <= 1'b0;
      end
      if (cmd.capture) begin
        if (!slotValid[0]) begin
          slotTime[0]  <= tod;
          slotValid[0] <= 1'b1;
        end else if (!slotValid[1]) begin
          slotTime[1]  <= tod;
          slotValid[1] <= 1'b1;
        end
      end
    end
  end

  p_held_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !run |=> (tod.sec == '0 && tod.ns == '0 && tod.frac == '0));

  p_ns_range_r3: assert property (@(posedge clk) disable iff (rst)
    (run && ({1'b0, tod.ns} < NS_LIM) && !cmd.load && !cmd.inc && !cmd.dec) |=> ({1'b0, tod.ns} < NS_LIM));

  p_fill_first_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd.capture && !slotValid[0]) |=> (slotValid[0] && slotTime[0] == $past(tod)));

  p_full_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd.capture && (&slotValid) && !(|cmd.clear)) |=> ($stable(slotTime) && (&slotValid)));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd.clear[0] && !cmd.capture) |=> !slotValid[0]);
endmodule

// File: rtl/tod_cmd_unit.sv
module tod_cmd_unit
  import tod_pkg::*;
#(
  parameter int STEP_NS_INIT   = 3,
  parameter int STEP_FRAC_INIT = 0,
  parameter int NS_PER_SEC     = 1000000000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [4:0]  wrAddr,
  input  logic [15:0] wrData,
  input  logic        rdEn,
  input  logic [4:0]  rdAddr,
  output logic [15:0] rdData,
  input  logic        evtIn
);
  todTime_t [NSLOT-1:0] slotTime;
  logic [NSLOT-1:0]     slotValid;
  logic                 run;
  todTime_t             loadVal;
  logic [15:0]          stepNs;
  logic [FRAC_W-1:0]    stepFrac;
  todCmd_t              cmd;

  tod_ctrl #(.STEP_NS_INIT(STEP_NS_INIT), .STEP_FRAC_INIT(STEP_FRAC_INIT)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .evtIn(evtIn),
    .slotTime(slotTime), .slotValid(slotValid), .run(run), .loadVal(loadVal),
    .stepNs(stepNs), .stepFrac(stepFrac), .cmd(cmd)
  );

  tod_datapath #(.NS_PER_SEC(NS_PER_SEC)) u_dp (
    .clk(clk), .rst(rst), .run(run), .loadVal(loadVal), .stepNs(stepNs),
    .stepFrac(stepFrac), .cmd(cmd), .slotTime(slotTime), .slotValid(slotValid)
  );
endmodule

// File: tb/tod_cmd_unit_test.sv
module tod_cmd_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [4:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        evtIn = 1'b0;
  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tod_cmd_unit uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .evtIn(evtIn)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, input logic clr, output logic [15:0] v);
    rdAddr = a; rdEn = clr;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic chkStatus(input string tag, input logic [15:0] exp);
    logic [15:0] v;
    rd(5'd12, 1'b0, v);
    chk(tag, 64'(v), 64'(exp));
  endtask

  task automatic setOperand(input logic [47:0] s, input logic [31:0] n, input logic [31:0] f);
    wr(5'd2, s[47:32]); wr(5'd3, s[31:16]); wr(5'd4, s[15:0]);
    wr(5'd5, n[31:16]); wr(5'd6, n[15:0]);
    wr(5'd7, f[31:16]); wr(5'd8, f[15:0]);
  endtask

  task automatic fire(input logic [2:0] code);
    wr(5'd1, {11'd0, code, 2'b01});
  endtask

  task automatic chkSlot(input int slot, input logic [47:0] s, input logic [31:0] n,
                         input logic [31:0] f, input string tag);
    logic [15:0] exp [7];
    logic [15:0] v;
    exp[0] = s[47:32]; exp[1] = s[31:16]; exp[2] = s[15:0];
    exp[3] = n[31:16]; exp[4] = n[15:0]; exp[5] = f[31:16]; exp[6] = f[15:0];
    for (int w = 0; w < 7; w++) begin
      rd(5'(16 + slot * 8 + w), (w == 6), v);
      chk($sformatf("%s slot%0d word%0d", tag, slot, w), 64'(v), 64'(exp[w]));
    end
  endtask

  task automatic t_reset_and_hold;
    chkStatus("R1 status after reset", 16'h0);
    fire(3'd4);
    evtIn = 1'b1; idle(2); evtIn = 1'b0;
    chkStatus("R1 triggers ignored while held", 16'h0);
    wr(5'd0, 16'h1);
  endtask

  task automatic t_step_wrap_slots;
    logic [15:0] v;
    setOperand(48'h123456789ABC, 32'd999999990, 32'h0);
    fire(3'd0);
    fire(3'd4);
    idle(3);
    fire(3'd4);
    chkStatus("R9 both slots valid", 16'h3);
    fire(3'd4);
    chkSlot(0, 48'h123456789ABC, 32'd999999990, 32'h0, "R4 load then capture");
    chkStatus("R9 slot0 cleared by last-word read", 16'h2);
    chkSlot(1, 48'h123456789ABD, 32'd2, 32'h0, "R3 R2 wrap after 4 steps, R8 full dropped");
    chkStatus("R9 slot1 cleared", 16'h0);
    rd(5'd17, 1'b1, v);
    chkStatus("R9 non-last word read keeps flags", 16'h0);
  endtask

  task automatic t_increment;
    setOperand(48'd5, 32'd999999000, 32'h0);
    fire(3'd0);
    setOperand(48'd2, 32'd1500, 32'h0);
    fire(3'd2);
    fire(3'd4);
    chkSlot(0, 48'd8, 32'd524, 32'h0, "R6 increment with carry");
  endtask

  task automatic t_decrement;
    setOperand(48'd5, 32'd100, 32'h0);
    fire(3'd0);
    setOperand(48'd1, 32'd200, 32'h0);
    fire(3'd3);
    fire(3'd4);
    chkSlot(0, 48'd3, 32'd999999924, 32'h0, "R7 decrement with borrow");
  endtask

  task automatic t_freq;
    wr(5'd7, 16'h4000); wr(5'd8, 16'h0000);
    fire(3'd1);
    setOperand(48'd0, 32'd0, 32'h0);
    fire(3'd0);
    idle(2);
    fire(3'd4);
    chkSlot(0, 48'd0, 32'd6, 32'h80000000, "R5 trim +0.25ns over 2 steps");
    fire(3'd1);
  endtask

  task automatic t_signed_step;
    wr(5'd10, 16'hC000); wr(5'd11, 16'h0000);
    fire(3'd0);
    idle(3);
    fire(3'd4);
    chkSlot(0, 48'd0, 32'd8, 32'h40000000, "R2 signed fractional step 2.75ns");
    wr(5'd10, 16'h0000);
  endtask

  task automatic t_event;
    setOperand(48'd0, 32'd1000, 32'h0);
    fire(3'd0);
    wr(5'd1, {11'd0, 3'd4, 2'b00});
    chkStatus("R10 code write without trigger does nothing", 16'h0);
    evtIn = 1'b1; idle(3); evtIn = 1'b0;
    chkStatus("R11 one capture per event edge", 16'h1);
    chkSlot(0, 48'd0, 32'd1006, 32'h0, "R11 event captures stored code");
    fire(3'd7);
    chkStatus("R10 code 7 no action", 16'h0);
  endtask

  task automatic t_rerun;
    wr(5'd0, 16'h0);
    wr(5'd0, 16'h1);
    fire(3'd4);
    chkSlot(0, 48'd0, 32'd0, 32'h0, "R1 time zero after hold");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_and_hold();
    t_step_wrap_slots();
    t_increment();
    t_decrement();
    t_freq();
    t_signed_step();
    t_event();
    t_rerun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      vecs++; errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule